// File: doc/BRIEF.md
# System Operating-Mode Controller

This block holds the operating mode of a processor-bus memory controller and drives the pins that mode governs. There are three modes. In normal mode the integer unit owns the bus. In power-down mode the bus is taken away from the integer unit so DMA can use it freely. In error halt the processor is stopped, timers and the serial port are frozen, and only a cold reset brings the system back.

Software asks for power-down by writing the power-down register, but the request only counts if the power-down enable bit in the control register is set. An external interrupt ends power-down. Four error sources can each be set to halt or to a masked report. Source 0 is a parity error, source 1 an uncorrectable EDAC error, source 2 a comparison error and source 3 the integer unit's error-mode signal. A masked error only pulses the system-error output. Software can also inject an error: it first sets an error-write-enable flag, then writes an error code.

All outputs are registered. Each one changes on the clock edge that samples the input which causes the change.

Top module: `sys_mode_ctrl`

## Requirements
- R1: After reset (synchronous `rst` high) the mode is normal and the outputs are `bus_hold_n`=1, all three `*_oe_n`=0, `cpu_halt_n`=1, `sys_err_n`=1, `tmr_freeze`=0, `uart_stop`=0 and `dma_gnt_n`=1.
- R2: When `pd_wr` is sampled in normal mode while control bit 0 (power-down enable) is 1, power-down starts on that edge. From then on `bus_hold_n`=0 and `addr_oe_n`=`ctl_oe_n`=`dat_oe_n`=1, and these levels hold for as long as power-down lasts.
- R3: When `pd_wr` is sampled while control bit 0 is 0, it is ignored and the outputs keep their normal-mode levels.
- R4: When `ext_irq` is sampled during power-down, the block returns to normal mode on that edge: `bus_hold_n`=1 and the three enables are 0. In normal mode `ext_irq` has no effect.
- R5: When error source i (`err_src[i]`) is sampled while control bit i+1 is 1 (halt), error halt starts on that edge. In error halt `cpu_halt_n`=0, `sys_err_n`=0, `tmr_freeze`=1 and `uart_stop`=1, with `bus_hold_n`=1 and the enables at 0.
- R6: An error whose control select bit is 0 (masked) drives `sys_err_n` low for exactly one cycle. The mode does not change and `cpu_halt_n` stays 1.
- R7: Error halt persists until reset. `ext_irq`, `pd_wr`, control writes and test-control writes have no effect in that mode.
- R8: When `esr_wr` is sampled, `esr_code[i]` counts as error source i, but only while the error-write-enable flag is 1. The flag is set by `tst_wr` with `tst_ewe`=1. While the flag is 0, `esr_wr` has no effect at all.
- R9: An error selected for halt that arrives during power-down moves the block straight to error halt.
- R10: In power-down and error halt, `dma_gnt_n` goes to 0 on the edge that samples `dma_req`=1, whatever `bus_idle` is, and follows the request from then on.
- R11: In normal mode a grant is given only on an edge that samples `dma_req`=1 and `bus_idle`=1. It is then held while `dma_req` stays 1, and it is released on the edge that samples `dma_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Cold reset, synchronous, active high |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | NSRC+1 | Bit 0 power-down enable; bit i+1 halt select for source i |
| pd_wr | input | 1 | Power-down register write strobe |
| tst_wr | input | 1 | Test-control write strobe |
| tst_ewe | input | 1 | Error-write-enable value written by `tst_wr` |
| esr_wr | input | 1 | Error-status register write strobe |
| esr_code | input | NSRC | Injected error code, one bit per source |
| ext_irq | input | 1 | External interrupt |
| err_src | input | NSRC | Hardware error events |
| dma_req | input | 1 | DMA request, active high |
| bus_idle | input | 1 | Integer unit is not using the bus |
| bus_hold_n | output | 1 | Bus hold to integer unit, active low |
| addr_oe_n | output | 1 | Address output enable, active low |
| ctl_oe_n | output | 1 | Control output enable, active low |
| dat_oe_n | output | 1 | Data output enable, active low |
| cpu_halt_n | output | 1 | CPU halt, active low |
| sys_err_n | output | 1 | System error, active low |
| tmr_freeze | output | 1 | Freeze all timers |
| uart_stop | output | 1 | Stop UART operation |
| dma_gnt_n | output | 1 | DMA grant, active low |

## Verification
Power-down requests are tried both with and without the enable bit, which shows whether the enable actually gates entry. Each of the four error sources is driven once with its select bit set to halt and once with it masked, which separates halt entry from a one-cycle error report and catches a wrong bit mapping. Error injection is tried before and after the test flag is set, and an error is also raised during power-down, which checks the priority of halt over power-down. DMA requests are driven with the bus busy and with it idle in each mode, which shows whether the special modes bypass the idle check.

// File: rtl/sysmode_pkg.sv
package sysmode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_SLEEP = 2'd1,
    MODE_HALT  = 2'd2
  } mode_t;
endpackage

// File: rtl/sm_cfg_regs.sv
module sm_cfg_regs #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lock,
  input  logic            ctl_wr,
  input  logic [NSRC:0]   ctl_wdata,
  input  logic            tst_wr,
  input  logic            tst_ewe,
  output logic            pd_en,
  output logic [NSRC-1:0] halt_sel,
  output logic            ewe
);
  // Writes are frozen while halted.
  always_ff @(posedge clk) begin
    if (rst) begin
      pd_en    <= 1'b0;
      halt_sel <= '0;
      ewe      <= 1'b0;
    end else if (!lock) begin
      if (ctl_wr) begin
        pd_en    <= ctl_wdata[0];
        halt_sel <= ctl_wdata[NSRC:1];
      end
      if (tst_wr) ewe <= tst_ewe;
    end
  end

  a_r7_cfg_locked: assert property (@(posedge clk) disable iff (rst)
    lock |=> ($stable(halt_sel) && $stable(pd_en) && $stable(ewe)));
endmodule

// File: rtl/sm_err_qual.sv
module sm_err_qual #(
  parameter int NSRC = 4
) (
  input  logic [NSRC-1:0] err_src,
  input  logic            esr_wr,
  input  logic [NSRC-1:0] esr_code,
  input  logic            ewe,
  input  logic [NSRC-1:0] halt_sel,
  output logic            halt_hit,
  output logic            mask_hit
);
  logic [NSRC-1:0] ev_halt, ev_mask;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic ev;
    assign ev         = err_src[i] | (esr_wr & ewe & esr_code[i]);
    assign ev_halt[i] = ev & halt_sel[i];
    assign ev_mask[i] = ev & ~halt_sel[i];
  end

  assign halt_hit = |ev_halt;
  assign mask_hit = |ev_mask;
endmodule

// File: rtl/sm_mode_fsm.sv
module sm_mode_fsm
  import sysmode_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  pd_en,
  input  logic  pd_wr,
  input  logic  ext_irq,
  input  logic  halt_hit,
  input  logic  mask_hit,
  output mode_t mode,
  output mode_t mode_nxt,
  output logic  bus_hold_n,
  output logic  addr_oe_n,
  output logic  ctl_oe_n,
  output logic  dat_oe_n,
  output logic  cpu_halt_n,
  output logic  sys_err_n,
  output logic  tmr_freeze,
  output logic  uart_stop
);
  always_comb begin
    mode_nxt = mode;
    unique case (mode)
      MODE_RUN: begin
        if (halt_hit)            mode_nxt = MODE_HALT;
        else if (pd_wr && pd_en) mode_nxt = MODE_SLEEP;
      end
      MODE_SLEEP: begin
        if (halt_hit)     mode_nxt = MODE_HALT;
        else if (ext_irq) mode_nxt = MODE_RUN;
      end
      default: mode_nxt = MODE_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= MODE_RUN;
      bus_hold_n <= 1'b1;
      addr_oe_n  <= 1'b0;
      ctl_oe_n   <= 1'b0;
      dat_oe_n   <= 1'b0;
      cpu_halt_n <= 1'b1;
      sys_err_n  <= 1'b1;
      tmr_freeze <= 1'b0;
      uart_stop  <= 1'b0;
    end else begin
      mode       <= mode_nxt;
      bus_hold_n <= (mode_nxt != MODE_SLEEP);
      addr_oe_n  <= (mode_nxt == MODE_SLEEP);
      ctl_oe_n   <= (mode_nxt == MODE_SLEEP);
      dat_oe_n   <= (mode_nxt == MODE_SLEEP);
      cpu_halt_n <= (mode_nxt != MODE_HALT);
      sys_err_n  <= !((mode_nxt == MODE_HALT) || mask_hit);
      tmr_freeze <= (mode_nxt == MODE_HALT);
      uart_stop  <= (mode_nxt == MODE_HALT);
    end
  end

  a_r2_sleep_pins: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SLEEP) |-> (!bus_hold_n && addr_oe_n && ctl_oe_n && dat_oe_n));
  a_r3_pd_gated: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RUN && pd_wr && !pd_en && !halt_hit) |=> (mode == MODE_RUN));
  a_r4_irq_wakes: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SLEEP && ext_irq && !halt_hit) |=> (mode == MODE_RUN && bus_hold_n));
  a_r5_halt_pins: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HALT) |-> (!cpu_halt_n && !sys_err_n && tmr_freeze && uart_stop));
  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HALT) |=> (mode == MODE_HALT));
  a_r6_mask_no_halt: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RUN && mask_hit && !halt_hit && !pd_wr) |=> (!sys_err_n && cpu_halt_n));
endmodule

// File: rtl/sm_dma_arb.sv
module sm_dma_arb (
  input  logic clk,
  input  logic rst,
  input  logic special,
  input  logic dma_req,
  input  logic bus_idle,
  output logic dma_gnt_n
);
  always_ff @(posedge clk) begin
    if (rst)             dma_gnt_n <= 1'b1;
    else if (special)    dma_gnt_n <= !dma_req;
    else if (!dma_gnt_n) dma_gnt_n <= !dma_req;
    else                 dma_gnt_n <= !(dma_req && bus_idle);
  end

  a_r10_special_grant: assert property (@(posedge clk) disable iff (rst)
    (special && dma_req) |=> !dma_gnt_n);
  a_r11_wait_idle: assert property (@(posedge clk) disable iff (rst)
    (!special && dma_gnt_n && !bus_idle) |=> dma_gnt_n);
  a_r11_release: assert property (@(posedge clk) disable iff (rst)
    !dma_req |=> dma_gnt_n);
endmodule

// File: rtl/sys_mode_ctrl.sv
module sys_mode_ctrl
  import sysmode_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctl_wr,
  input  logic [NSRC:0]   ctl_wdata,
  input  logic            pd_wr,
  input  logic            tst_wr,
  input  logic            tst_ewe,
  input  logic            esr_wr,
  input  logic [NSRC-1:0] esr_code,
  input  logic            ext_irq,
  input  logic [NSRC-1:0] err_src,
  input  logic            dma_req,
  input  logic            bus_idle,
  output logic            bus_hold_n,
  output logic            addr_oe_n,
  output logic            ctl_oe_n,
  output logic            dat_oe_n,
  output logic            cpu_halt_n,
  output logic            sys_err_n,
  output logic            tmr_freeze,
  output logic            uart_stop,
  output logic            dma_gnt_n
);
  mode_t           mode, mode_nxt;
  logic            pd_en, ewe, halt_hit, mask_hit;
  logic [NSRC-1:0] halt_sel;

  sm_cfg_regs #(.NSRC(NSRC)) u_cfg (
    .clk(clk), .rst(rst), .lock(mode == MODE_HALT),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .tst_wr(tst_wr), .tst_ewe(tst_ewe),
    .pd_en(pd_en), .halt_sel(halt_sel), .ewe(ewe)
  );

  sm_err_qual #(.NSRC(NSRC)) u_err (
    .err_src(err_src), .esr_wr(esr_wr), .esr_code(esr_code), .ewe(ewe),
    .halt_sel(halt_sel), .halt_hit(halt_hit), .mask_hit(mask_hit)
  );

  sm_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .pd_en(pd_en), .pd_wr(pd_wr), .ext_irq(ext_irq),
    .halt_hit(halt_hit), .mask_hit(mask_hit), .mode(mode), .mode_nxt(mode_nxt),
    .bus_hold_n(bus_hold_n), .addr_oe_n(addr_oe_n), .ctl_oe_n(ctl_oe_n),
    .dat_oe_n(dat_oe_n), .cpu_halt_n(cpu_halt_n), .sys_err_n(sys_err_n),
    .tmr_freeze(tmr_freeze), .uart_stop(uart_stop)
  );

  sm_dma_arb u_dma (
    .clk(clk), .rst(rst), .special(mode_nxt != MODE_RUN),
    .dma_req(dma_req), .bus_idle(bus_idle), .dma_gnt_n(dma_gnt_n)
  );

  a_r9_sleep_to_halt: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SLEEP && halt_hit) |=> (mode == MODE_HALT && bus_hold_n));
endmodule

// File: tb/sim_sys_mode_ctrl.sv
module sim_sys_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 4;
  localparam int WD_CYCLES = 5000;
  localparam logic [7:0] O_RUN = 8'h8C, O_SLEEP = 8'h7C, O_HALT = 8'h83, O_MASK = 8'h88;

  logic clk = 1'b0, rst = 1'b1;
  logic ctl_wr = 0, pd_wr = 0, tst_wr = 0, tst_ewe = 0, esr_wr = 0, ext_irq = 0;
  logic dma_req = 0, bus_idle = 0;
  logic [NSRC:0]   ctl_wdata = '0;
  logic [NSRC-1:0] esr_code = '0, err_src = '0;
  logic bus_hold_n, addr_oe_n, ctl_oe_n, dat_oe_n, cpu_halt_n, sys_err_n;
  logic tmr_freeze, uart_stop, dma_gnt_n;
  logic [7:0] outs;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_mode_ctrl #(.NSRC(NSRC)) u0 (.*);

  assign outs = {bus_hold_n, addr_oe_n, ctl_oe_n, dat_oe_n,
                 cpu_halt_n, sys_err_n, tmr_freeze, uart_stop};

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; ctl_wr = 0; pd_wr = 0; tst_wr = 0; esr_wr = 0; ext_irq = 0;
    err_src = '0; dma_req = 0; bus_idle = 0;
    step(); step(); rst = 0;
  endtask

  task automatic write_ctl(logic [NSRC:0] v);
    ctl_wr = 1; ctl_wdata = v; step(); ctl_wr = 0;
  endtask

  task automatic enter_sleep();
    pd_wr = 1; step(); pd_wr = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 outputs", outs, O_RUN);
    chk("R1 grant", {7'd0, dma_gnt_n}, 8'd1);
  endtask

  task automatic t_pd_disabled();
    do_reset();
    write_ctl('0);
    enter_sleep();
    chk("R3 pd ignored", outs, O_RUN);
  endtask

  task automatic t_pd_cycle();
    do_reset();
    write_ctl(5'b00001);
    enter_sleep();
    chk("R2 enter", outs, O_SLEEP);
    repeat (3) step();
    chk("R2 held", outs, O_SLEEP);
    ext_irq = 1; step(); ext_irq = 0;
    chk("R4 wake", outs, O_RUN);
    ext_irq = 1; step(); ext_irq = 0;
    chk("R4 irq in run", outs, O_RUN);
  endtask

  task automatic t_dma_normal();
    do_reset();
    dma_req = 1; bus_idle = 0; step();
    chk("R11 busy no grant", {7'd0, dma_gnt_n}, 8'd1);
    bus_idle = 1; step();
    chk("R11 grant on idle", {7'd0, dma_gnt_n}, 8'd0);
    bus_idle = 0; step();
    chk("R11 grant held", {7'd0, dma_gnt_n}, 8'd0);
    dma_req = 0; step();
    chk("R11 release", {7'd0, dma_gnt_n}, 8'd1);
  endtask

  task automatic t_dma_sleep();
    do_reset();
    write_ctl(5'b00001);
    enter_sleep();
    dma_req = 1; bus_idle = 0; step();
    chk("R10 sleep grant", {7'd0, dma_gnt_n}, 8'd0);
    dma_req = 0; step();
    chk("R10 sleep release", {7'd0, dma_gnt_n}, 8'd1);
  endtask

  task automatic t_masked();
    for (int i = 0; i < NSRC; i++) begin
      do_reset();
      write_ctl('0);
      err_src = NSRC'(1) << i; step(); err_src = '0;
      chk($sformatf("R6 masked src%0d pulse", i), outs, O_MASK);
      step();
      chk($sformatf("R6 masked src%0d after", i), outs, O_RUN);
    end
  endtask

  task automatic t_hw_halt();
    for (int i = 0; i < NSRC; i++) begin
      do_reset();
      write_ctl((NSRC+1)'(1) << (i + 1));
      err_src = NSRC'(1) << i; step(); err_src = '0;
      chk($sformatf("R5 halt src%0d", i), outs, O_HALT);
    end
  endtask

  task automatic t_halt_sticky();
    do_reset();
    write_ctl(5'b00011);
    err_src = 4'b0001; step(); err_src = '0;
    ext_irq = 1; step(); ext_irq = 0;
    chk("R7 irq ignored", outs, O_HALT);
    write_ctl('0);
    pd_wr = 1; step(); pd_wr = 0;
    chk("R7 writes ignored", outs, O_HALT);
    dma_req = 1; bus_idle = 0; step();
    chk("R10 halt grant", {7'd0, dma_gnt_n}, 8'd0);
    dma_req = 0;
    do_reset();
    chk("R7 reset exits", outs, O_RUN);
  endtask

  task automatic t_sw_halt();
    do_reset();
    write_ctl(5'b00010);
    esr_wr = 1; esr_code = 4'b0001; step(); esr_wr = 0;
    chk("R8 no ewe ignored", outs, O_RUN);
    tst_wr = 1; tst_ewe = 1; step(); tst_wr = 0;
    esr_wr = 1; esr_code = 4'b0001; step(); esr_wr = 0;
    chk("R8 injected halt", outs, O_HALT);
  endtask

  task automatic t_sleep_err();
    do_reset();
    write_ctl(5'b01001);
    enter_sleep();
    err_src = 4'b0100; step(); err_src = '0;
    chk("R9 sleep to halt", outs, O_HALT);
  endtask

  initial begin
    t_reset();
    t_pd_disabled();
    t_pd_cycle();
    t_dma_normal();
    t_dma_sleep();
    t_masked();
    t_hw_halt();
    t_halt_sticky();
    t_sw_halt();
    t_sleep_err();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule